// File: doc/BRIEF.md
# Windowed Address Translator Between Local and PCI Buses

This block rewrites bus addresses as they pass between a local processor bus and a 32-bit PCI bus. Each direction has its own set of up to three address windows. An incoming address is compared with every configured window of the selected direction. When a window matches, the high-order bits that define that window are replaced by a target prefix, and the offset bits below them pass through unchanged. The set of replaced bits is derived from each window's base and high address: it is every bit from the most significant one down to, but not including, the first bit at which the two differ.

The prefixes for local-to-PCI windows are chosen at build time. They are either fixed parameters or registers that can be rewritten at run time through a small write port. The result is registered and appears one cycle after the request. It carries a hit flag, the index of the winning window, and that window's space type. For I/O-space windows the two lowest address bits are preserved. For memory-space windows they are cleared, because byte selection is carried on separate byte lanes. Translation takes place in the source bus's own clock domain, before the address crosses into the other domain.

Top module: `bar_xlate`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` from the previous clock edge. After reset, `out_valid` and `out_hit` are 0.
- R2: An address matches a window when its bits above the window's first differing base/high bit equal the base's bits. Addresses outside every configured window do not match.
- R3: On a hit, the output address takes the window's prefix in the replaced bit positions and the input's bits in the offset positions. Bits [1:0] follow R9.
- R4: With a PCI-to-local window spanning 0x12000000–0x12FFFFFF, memory space and prefix 0xFE000000, PCI address 0x1235FEDC yields local address 0xFE35FEDC.
- R5: With register prefixes enabled, writing 0xFEDC0000 to local window 0 (base 0xABCDE000, high 0xABCDFFFF, I/O space) makes local address 0xABCDF123 yield 0xFEDC1123.
- R6: When several windows match, the one with the lowest index wins and `out_idx` reports it.
- R7: On a miss, `out_hit` is 0 and `out_idx` is 0.
- R8: Windows whose index is at or above the configured count for their direction (`NUM_LOC`, `NUM_PCI`, each 1 to 3) never match, and writes aimed at such an index change nothing.
- R9: `out_mem` gives the winning window's space (1 = memory, 0 = I/O). For I/O, `out_addr[1:0]` equals `in_addr[1:0]`. For memory, `out_addr[1:0]` is 00.
- R10: In register mode, a write sets the prefix of local window `wr_idx` for requests presented on later cycles. A request in the same cycle as the write still uses the old prefix. Reset loads the parameter prefixes. In parameter mode, writes are ignored.
- R11: `in_dir` = 0 selects the local-to-PCI window set. `in_dir` = 1 selects the PCI-to-local set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the requesting bus |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_dir | input | 1 | 0 = local to PCI, 1 = PCI to local |
| in_addr | input | 32 | Address to translate |
| wr_en | input | 1 | Prefix register write strobe |
| wr_idx | input | 2 | Local window whose prefix is written |
| wr_data | input | 32 | New prefix value |
| out_valid | output | 1 | Result present |
| out_hit | output | 1 | A window matched |
| out_idx | output | 2 | Index of the winning window |
| out_mem | output | 1 | Winning window is memory space |
| out_addr | output | 32 | Translated address |

## Verification
A corrupted prefix register shows up as a wrong upper address on the first local-to-PCI request after the corruption, one cycle after that request. A wrong mask width shows up as a wrong boundary. Offset bits leak into the prefix field, or prefix bits leak into the offset field, on the very next hit in that window. Priority or window-count faults change `out_idx` or `out_hit` immediately. For these reasons the stimulus places addresses just inside and just outside each window edge, and places addresses where two windows overlap.

// File: rtl/bar_xlate_pkg.sv
package bar_xlate_pkg;
  localparam int ADDR_W  = 32;
  localparam int MAX_WIN = 3;
  localparam int IDX_W   = 2;

  // Replaced bits: from the MSB down to the first bit where base and high differ.
  function automatic logic [ADDR_W-1:0] keep_mask(input logic [ADDR_W-1:0] b,
                                                  input logic [ADDR_W-1:0] h);
    logic [ADDR_W-1:0] m;
    logic              done;
    m    = '0;
    done = 1'b0;
    for (int i = ADDR_W-1; i >= 0; i--) begin
      if (!done && (b[i] == h[i])) m[i] = 1'b1;
      else                         done = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bar_win_match.sv
module bar_win_match
  import bar_xlate_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] HIGH = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prefix,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  localparam logic [ADDR_W-1:0] MASK = keep_mask(BASE, HIGH);

  always_comb begin
    hit   = (((addr ^ BASE) & MASK) == '0);
    xaddr = (prefix & MASK) | (addr & ~MASK);
  end
endmodule

// File: rtl/bar_prefix_regs.sv
module bar_prefix_regs
  import bar_xlate_pkg::*;
#(
  parameter int                          NWIN    = 3,
  parameter bit                          USE_REG = 1'b1,
  parameter logic [MAX_WIN*ADDR_W-1:0]   INIT    = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [ADDR_W-1:0]           wr_data,
  output logic [MAX_WIN*ADDR_W-1:0]   prefix
);
  for (genvar w = 0; w < MAX_WIN; w++) begin : g_win
    if (USE_REG && (w < NWIN)) begin : g_reg
      logic [ADDR_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                 q <= INIT[w*ADDR_W +: ADDR_W];
        else if (wr_en && (wr_idx == IDX_W'(w))) q <= wr_data;
      end
      assign prefix[w*ADDR_W +: ADDR_W] = q;
    end else begin : g_fix
      assign prefix[w*ADDR_W +: ADDR_W] = INIT[w*ADDR_W +: ADDR_W];
    end
  end
endmodule

// File: rtl/bar_pick.sv
module bar_pick
  import bar_xlate_pkg::*;
(
  input  logic [MAX_WIN-1:0]        hits,
  input  logic [MAX_WIN*ADDR_W-1:0] xaddrs,
  output logic                      any,
  output logic [IDX_W-1:0]          idx,
  output logic [ADDR_W-1:0]         addr
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    addr = '0;
    for (int w = MAX_WIN-1; w >= 0; w--) begin
      if (hits[w]) begin
        any  = 1'b1;
        idx  = IDX_W'(w);
        addr = xaddrs[w*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/bar_xlate.sv
module bar_xlate
  import bar_xlate_pkg::*;
#(
  parameter int                        NUM_LOC    = 3,
  parameter int                        NUM_PCI    = 2,
  parameter bit                        USE_REG    = 1'b1,
  parameter logic [MAX_WIN*ADDR_W-1:0] LOC_BASE   = {32'h4000_0000, 32'h4000_0000, 32'hABCD_E000},
  parameter logic [MAX_WIN*ADDR_W-1:0] LOC_HIGH   = {32'h4FFF_FFFF, 32'h4000_0FFF, 32'hABCD_FFFF},
  parameter logic [MAX_WIN*ADDR_W-1:0] LOC_PREFIX = {32'h9000_0000, 32'h1234_5000, 32'h0000_0000},
  parameter logic [MAX_WIN-1:0]        LOC_MEM    = 3'b010,
  parameter logic [MAX_WIN*ADDR_W-1:0] PCI_BASE   = {32'h5500_0000, 32'h0000_0000, 32'h1200_0000},
  parameter logic [MAX_WIN*ADDR_W-1:0] PCI_HIGH   = {32'h55FF_FFFF, 32'h0000_FFFF, 32'h12FF_FFFF},
  parameter logic [MAX_WIN*ADDR_W-1:0] PCI_PREFIX = {32'h7700_0000, 32'h2000_0000, 32'hFE00_0000},
  parameter logic [MAX_WIN-1:0]        PCI_MEM    = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_dir,
  input  logic [31:0]       in_addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [31:0]       wr_data,
  output logic              out_valid,
  output logic              out_hit,
  output logic [1:0]        out_idx,
  output logic              out_mem,
  output logic [31:0]       out_addr
);
  logic [MAX_WIN*ADDR_W-1:0] loc_prefix;
  logic [MAX_WIN-1:0]        loc_hits, pci_hits;
  logic [MAX_WIN*ADDR_W-1:0] loc_x, pci_x;
  logic                      loc_any, pci_any;
  logic [IDX_W-1:0]          loc_idx, pci_idx;
  logic [ADDR_W-1:0]         loc_addr, pci_addr;

  bar_prefix_regs #(.NWIN(NUM_LOC), .USE_REG(USE_REG), .INIT(LOC_PREFIX)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .prefix(loc_prefix)
  );

  for (genvar w = 0; w < MAX_WIN; w++) begin : g_w
    if (w < NUM_LOC) begin : g_loc
      bar_win_match #(.BASE(LOC_BASE[w*ADDR_W +: ADDR_W]),
                      .HIGH(LOC_HIGH[w*ADDR_W +: ADDR_W])) u_m (
        .addr(in_addr), .prefix(loc_prefix[w*ADDR_W +: ADDR_W]),
        .hit(loc_hits[w]), .xaddr(loc_x[w*ADDR_W +: ADDR_W])
      );
    end else begin : g_loc_off
      assign loc_hits[w]               = 1'b0;
      assign loc_x[w*ADDR_W +: ADDR_W] = '0;
    end
    if (w < NUM_PCI) begin : g_pci
      bar_win_match #(.BASE(PCI_BASE[w*ADDR_W +: ADDR_W]),
                      .HIGH(PCI_HIGH[w*ADDR_W +: ADDR_W])) u_m (
        .addr(in_addr), .prefix(PCI_PREFIX[w*ADDR_W +: ADDR_W]),
        .hit(pci_hits[w]), .xaddr(pci_x[w*ADDR_W +: ADDR_W])
      );
    end else begin : g_pci_off
      assign pci_hits[w]               = 1'b0;
      assign pci_x[w*ADDR_W +: ADDR_W] = '0;
    end
  end

  bar_pick u_pick_loc (.hits(loc_hits), .xaddrs(loc_x), .any(loc_any), .idx(loc_idx), .addr(loc_addr));
  bar_pick u_pick_pci (.hits(pci_hits), .xaddrs(pci_x), .any(pci_any), .idx(pci_idx), .addr(pci_addr));

  logic              sel_hit, sel_mem;
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] sel_addr;

  always_comb begin
    sel_hit  = in_dir ? pci_any  : loc_any;
    sel_idx  = in_dir ? pci_idx  : loc_idx;
    sel_addr = in_dir ? pci_addr : loc_addr;
    sel_mem  = in_dir ? PCI_MEM[sel_idx] : LOC_MEM[sel_idx];
    if (sel_mem) sel_addr[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_mem   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid && sel_hit;
      out_idx   <= (in_valid && sel_hit) ? sel_idx : '0;
      out_mem   <= in_valid && sel_hit && sel_mem;
      out_addr  <= sel_addr;
    end
  end
endmodule

// File: rtl/bar_xlate_chk.sv
module bar_xlate_chk #(
  parameter int NUM_LOC = 3,
  parameter int NUM_PCI = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_dir,
  input logic [31:0] in_addr,
  input logic        out_valid,
  input logic        out_hit,
  input logic [1:0]  out_idx,
  input logic        out_mem,
  input logic [31:0] out_addr
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7
  miss_idx_chk: assert property (@(posedge clk) disable iff (rst)
    !out_hit |-> (out_idx == 2'd0));
  // R1
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_valid);
  // R9
  mem_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_hit && out_mem) |-> (out_addr[1:0] == 2'b00));
  // R9
  io_low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid ##1 (out_hit && !out_mem)) |-> (out_addr[1:0] == $past(in_addr[1:0])));
  // R8
  idx_in_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid ##1 out_hit) |->
      (32'(out_idx) < ($past(in_dir) ? NUM_PCI : NUM_LOC)));
endmodule

bind bar_xlate bar_xlate_chk #(.NUM_LOC(NUM_LOC), .NUM_PCI(NUM_PCI)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir), .in_addr(in_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_idx(out_idx), .out_mem(out_mem),
  .out_addr(out_addr)
);

// File: tb/bar_xlate_test.sv
module bar_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_dir = 1'b0;
  logic [31:0] in_addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        out_valid, out_hit, out_mem;
  logic [1:0]  out_idx;
  logic [31:0] out_addr;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  bar_xlate uut (.*);

  // Reference windows, written from the requirements: [dir][win]
  int unsigned m_base [2][3] = '{'{32'hABCD_E000, 32'h4000_0000, 32'h4000_0000},
                                 '{32'h1200_0000, 32'h0000_0000, 32'h5500_0000}};
  int unsigned m_high [2][3] = '{'{32'hABCD_FFFF, 32'h4000_0FFF, 32'h4FFF_FFFF},
                                 '{32'h12FF_FFFF, 32'h0000_FFFF, 32'h55FF_FFFF}};
  int unsigned m_pre  [2][3] = '{'{32'h0000_0000, 32'h1234_5000, 32'h9000_0000},
                                 '{32'hFE00_0000, 32'h2000_0000, 32'h7700_0000}};
  bit          m_mem  [2][3] = '{'{1'b0, 1'b1, 1'b0}, '{1'b1, 1'b0, 1'b1}};
  int          m_cnt  [2]    = '{3, 2};

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit d, input int unsigned a,
                      input bit we, input int widx, input int unsigned wd, input string tag);
    bit          e_hit = 0, e_mem = 0;
    int          e_idx = 0;
    int unsigned e_addr = 0;
    @(negedge clk);
    in_valid = v; in_dir = d; in_addr = a;
    wr_en = we; wr_idx = 2'(widx); wr_data = wd;
    for (int w = 0; w < m_cnt[d]; w++) begin
      if (!e_hit && a >= m_base[d][w] && a <= m_high[d][w]) begin
        longint unsigned sz = longint'(m_high[d][w]) - m_base[d][w] + 1;
        int unsigned off = int'(longint'(a) % sz);
        e_hit  = v;
        e_idx  = e_hit ? w : 0;
        e_mem  = e_hit && m_mem[d][w];
        e_addr = int'((longint'(m_pre[d][w]) / sz) * sz) + off;
        if (m_mem[d][w]) e_addr[1:0] = 2'b00;
      end
    end
    if (we && widx < m_cnt[0]) m_pre[0][widx] = wd;
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    chk(tag, "valid", out_valid, v);
    if (v) begin
      chk(tag, "hit", out_hit, e_hit);
      chk(tag, "idx", out_idx, e_idx);
      if (e_hit) begin
        chk(tag, "mem", out_mem, e_mem);
        chk(tag, "addr", out_addr, e_addr);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R1", "reset valid", out_valid, 0);
    chk("R1", "reset hit", out_hit, 0);
    step(0, 0, 32'hABCD_E000, 0, 0, 0, "R1");
    // R4: PCI to local example
    step(1, 1, 32'h1235_FEDC, 0, 0, 0, "R4");
    // R5: register prefix then local access
    step(0, 0, 0, 1, 0, 32'hFEDC_0000, "R10");
    step(1, 0, 32'hABCD_F123, 0, 0, 0, "R5");
    // R10: request in write cycle uses old prefix, next uses new
    step(1, 0, 32'hABCD_E007, 1, 0, 32'h3000_0000, "R10");
    step(1, 0, 32'hABCD_E007, 0, 0, 0, "R10");
    // R2: window edges
    step(1, 0, 32'hABCD_DFFF, 0, 0, 0, "R2");
    step(1, 0, 32'hABCD_FFFF, 0, 0, 0, "R2");
    step(1, 1, 32'h1300_0000, 0, 0, 0, "R2");
    // R6: overlap of windows 1 and 2, lower index wins
    step(1, 0, 32'h4000_0ABD, 0, 0, 0, "R6");
    // R3 / R9: window 2 only, I/O keeps low bits
    step(1, 0, 32'h4500_0003, 0, 0, 0, "R3");
    step(1, 0, 32'h4000_1002, 0, 0, 0, "R9");
    // R9: memory window clears low bits
    step(1, 1, 32'h12AB_CDEF, 0, 0, 0, "R9");
    step(1, 1, 32'h0000_1233, 0, 0, 0, "R11");
    // R8: PCI window 2 beyond count never hits; write to index 3 ignored
    step(1, 1, 32'h5500_0010, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 3, 32'hDEAD_0000, "R8");
    step(1, 0, 32'h4000_0100, 0, 0, 0, "R8");
    // R7: miss in both directions
    step(1, 0, 32'h0000_0040, 0, 0, 0, "R7");
    step(1, 1, 32'hABCD_F123, 0, 0, 0, "R7");
    // R11: same address, different direction
    step(1, 0, 32'h1235_FEDC, 0, 0, 0, "R11");
    // Back-to-back sweep through local window 2
    for (int i = 0; i < 16; i++) step(1, 0, 32'h4100_0000 + i * 32'h0111_1111, 0, 0, 0, "R3");
    // R10: rewrite window 2 prefix and reuse
    step(0, 0, 0, 1, 2, 32'hC000_0000, "R10");
    step(1, 0, 32'h4ABC_DEF1, 0, 0, 0, "R10");
    // R1: reset clears outputs and restores parameter prefix
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1", "post-reset valid", out_valid, 0);
    m_pre[0][0] = 32'h0000_0000;
    m_pre[0][2] = 32'h9000_0000;
    step(1, 0, 32'hABCD_F123, 0, 0, 0, "R10");
    step(1, 0, 32'h4ABC_DEF1, 0, 0, 0, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule